// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the serial core of an SPI master. It takes 32-bit words from a transmit queue, sends each word on the serial clock and data-out lines, and assembles what comes back on the data-in line into a 32-bit word for the receive queue. The serial clock runs at the reference clock divided by a power of two. Both clock polarity and clock phase can be set. Four active-low select lines are driven either by the engine, which asserts them only while a word is on the wire, or straight from software.

The engine takes plain configuration values: a 16-bit control word and a one-bit enable. It knows nothing of register addresses. Each word goes out as four bytes. The low byte is sent first, and within each byte the most significant bit leads. Received bits are placed in the word in the same order. A word is started only when the receive queue has room for the result. Clearing the enable drops any word in flight and returns the engine to idle.

Top module: `spim_engine`

## Requirements
- R1: After reset, and at any time no word is in flight, `sclk` equals control bit 1 (polarity), `txPop` and `rxPush` are low, and with control bit 14 clear `ssN` is 4'b1111.
- R2: A word starts only when `enable` is high, control bit 0 (master) is 1, `txValid` is high, `rxFull` is low and the engine is idle. `txPop` pulses for that one cycle. With control bit 0 at 0 no word starts.
- R3: Serial bit i (i = 0..31) of a word carries data bit 8*(i/8) + 7 - (i mod 8), on both `mosi` and `miso`.
- R4: With control bit 2 (phase) at 0, `mosi` holds bit 0 before the first leading `sclk` edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With phase at 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. A leading edge is one that moves `sclk` away from its polarity level.
- R5: Consecutive `sclk` edges are 2^n reference cycles apart, where n is control bits 5:3. The serial clock period is therefore 2<<n cycles. Each word takes exactly 64 edges, and `sclk` changes at no other time while a word is in flight.
- R6: After the 64th edge, `rxPush` pulses for exactly one cycle, with `rxData` holding the 32 sampled bits in the order given by R3.
- R7: While `rxFull` is high, no word starts and `txPop` stays low.
- R8: With control bit 14 at 0, `ssN` equals control bits 13:10, as captured when the word started, for the whole of the word. Between words `ssN` is 4'b1111.
- R9: With control bit 14 at 1, `ssN` follows control bits 13:10 combinationally at all times, busy or idle.
- R10: When `enable` goes low, the engine is idle from the next cycle. `sclk` returns to the polarity level, `ssN` (automatic mode) returns to 4'b1111, no `rxPush` is produced for the dropped word, and no new word starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWord | input | 16 | Control: 0 master, 1 polarity, 2 phase, 5:3 divisor code, 13:10 select field, 14 manual select |
| enable | input | 1 | Engine enable; low aborts and holds idle |
| txValid | input | 1 | Transmit queue holds a word |
| txData | input | 32 | Head word of the transmit queue |
| txPop | output | 1 | Takes the head word (one-cycle pulse) |
| rxFull | input | 1 | Receive queue cannot accept a word |
| rxPush | output | 1 | Writes `rxData` to the receive queue (one-cycle pulse) |
| rxData | output | 32 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 4 | Active-low slave selects |

## Verification
The bench plays the slave. It decodes edges from `sclk` alone, samples `mosi`, and drives `miso` from a known pattern, so a swapped phase, a reversed byte order or a wrong divisor each show up as a corrupt word or a wrong edge spacing. All four clock modes are swept against all eight divisor codes, with a data pattern that changes for every combination. All-zero, all-one and walking-bit words at the fastest divisor separate stuck bits from ordering faults. Further runs cover the master bit, back-pressure from a full receive queue, the manual select mode with a select field that changes while idle, and an abort in the middle of a word.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Control word field positions (decoded by neighbouring logic).
  localparam int CtlMasterBit = 0;
  localparam int CtlCpolBit   = 1;
  localparam int CtlCphaBit   = 2;
  localparam int CtlDivLsb    = 3;
  localparam int CtlSsLsb     = 10;
  localparam int CtlManualBit = 14;

  // Strobes from the sequencer to the datapath and select logic.
  typedef struct packed {
    logic load;   // word accepted this cycle
    logic lead;   // leading sclk edge this cycle
    logic trail;  // trailing sclk edge this cycle
    logic push;   // word complete, hand to receive queue
    logic abort;  // enable dropped while busy
  } engStrobe_t;

  // Serial position -> data bit: low byte first, MSB first in each byte.
  function automatic int unsigned serialBitPos(int unsigned idx, int unsigned byteW);
    return (idx / byteW) * byteW + (byteW - 1) - (idx % byteW);
  endfunction

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DIV_W     = 3,
  parameter int WORD_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             master,
  input  logic             txValid,
  input  logic             rxFull,
  input  logic [DIV_W-1:0] divCode,
  output engStrobe_t       strobe,
  output logic             busy,
  output logic             txPop
);

  localparam int EDGES  = 2 * WORD_BITS;
  localparam int EDGE_W = $clog2(EDGES);
  localparam int CNT_W  = (1 << DIV_W) - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} engState_t;

  engState_t        state;
  logic [DIV_W-1:0] divQ;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] halfLast;
  logic [EDGE_W-1:0] edgeCnt;
  logic             startOk;
  logic             edgeHit;

  assign halfLast = CNT_W'((32'd1 << divQ) - 32'd1);
  assign startOk  = enable && master && txValid && !rxFull && (state == ST_IDLE);
  assign edgeHit  = enable && (state == ST_SHIFT) && (divCnt == halfLast);

  always_comb begin
    strobe       = '0;
    strobe.load  = startOk;
    strobe.lead  = edgeHit && !edgeCnt[0];
    strobe.trail = edgeHit && edgeCnt[0];
    strobe.push  = enable && (state == ST_DONE);
    strobe.abort = !enable && (state != ST_IDLE);
  end

  assign busy  = (state != ST_IDLE);
  assign txPop = startOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divQ    <= '0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (!enable) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startOk) begin
            state   <= ST_SHIFT;
            divQ    <= divCode;
            divCnt  <= '0;
            edgeCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (edgeHit) begin
            divCnt  <= '0;
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == EDGE_W'(EDGES - 1)) state <= ST_DONE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_push_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> !strobe.push);

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);

  assert_no_start_when_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !busy) |=> !busy);

endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  engStrobe_t           strobe,
  input  logic                 busy,
  input  logic                 cpol,
  input  logic                 cpha,
  input  logic [WORD_BITS-1:0] txData,
  input  logic                 miso,
  output logic [WORD_BITS-1:0] rxData,
  output logic                 sclk,
  output logic                 mosi
);

  localparam int PTR_W = $clog2(WORD_BITS);
  localparam int IDX_W = PTR_W + 1;

  logic [WORD_BITS-1:0] txWord;
  logic [WORD_BITS-1:0] rxWord;
  logic [IDX_W-1:0]     bitIdx;
  logic                 mosiQ;
  logic                 phaseQ;
  logic                 cpolQ;
  logic                 cphaQ;
  logic                 sampleEv;
  logic                 shiftEv;
  logic [PTR_W-1:0]     curPos;
  logic [PTR_W-1:0]     firstPos;

  assign sampleEv = cphaQ ? strobe.trail : strobe.lead;
  assign shiftEv  = cphaQ ? strobe.lead  : strobe.trail;
  assign curPos   = PTR_W'(serialBitPos(32'(bitIdx), BYTE_BITS));
  assign firstPos = PTR_W'(serialBitPos(0, BYTE_BITS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord <= '0;
      rxWord <= '0;
      bitIdx <= '0;
      mosiQ  <= 1'b0;
      phaseQ <= 1'b0;
      cpolQ  <= 1'b0;
      cphaQ  <= 1'b0;
    end else if (strobe.load) begin
      txWord <= txData;
      rxWord <= '0;
      bitIdx <= '0;
      phaseQ <= 1'b0;
      cpolQ  <= cpol;
      cphaQ  <= cpha;
      mosiQ  <= cpha ? 1'b0 : txData[firstPos];
    end else if (strobe.abort || strobe.push) begin
      phaseQ <= 1'b0;
    end else begin
      if (strobe.lead || strobe.trail) phaseQ <= ~phaseQ;
      if (sampleEv) begin
        rxWord[curPos] <= miso;
        bitIdx         <= bitIdx + 1'b1;
      end
      if (shiftEv && (bitIdx < IDX_W'(WORD_BITS))) mosiQ <= txWord[curPos];
    end
  end

  assign sclk   = busy ? (cpolQ ^ phaseQ) : cpol;
  assign mosi   = mosiQ;
  assign rxData = rxWord;

  assert_sclk_moves_on_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.lead && !strobe.trail && !strobe.abort && !strobe.push) |=> $stable(sclk));

  assert_mosi_hold_on_sample_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cphaQ && strobe.lead) |=> $stable(mosi));

endmodule

// File: rtl/spim_csel.sv
module spim_csel #(
  parameter int SS_LINES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                manual,
  input  logic [SS_LINES-1:0] ssField,
  input  logic                load,
  input  logic                busy,
  output logic [SS_LINES-1:0] ssN
);

  logic [SS_LINES-1:0] ssLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     ssLatch <= '1;
    else if (load) ssLatch <= ssField;
  end

  assign ssN = manual ? ssField : (busy ? ssLatch : '1);

  assert_cs_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!manual && $past(!manual) && busy && $past(busy)) |-> $stable(ssN));

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int BYTE_BITS = 8,
  parameter int DIV_W     = 3,
  parameter int SS_LINES  = 4,
  parameter int CTRL_W    = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CTRL_W-1:0]    ctrlWord,
  input  logic                 enable,
  input  logic                 txValid,
  input  logic [WORD_BITS-1:0] txData,
  output logic                 txPop,
  input  logic                 rxFull,
  output logic                 rxPush,
  output logic [WORD_BITS-1:0] rxData,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic [SS_LINES-1:0]  ssN
);

  engStrobe_t strobe;
  logic       busy;

  spim_ctrl #(
    .DIV_W    (DIV_W),
    .WORD_BITS(WORD_BITS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .master (ctrlWord[CtlMasterBit]),
    .txValid(txValid),
    .rxFull (rxFull),
    .divCode(ctrlWord[CtlDivLsb +: DIV_W]),
    .strobe (strobe),
    .busy   (busy),
    .txPop  (txPop)
  );

  spim_datapath #(
    .WORD_BITS(WORD_BITS),
    .BYTE_BITS(BYTE_BITS)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .busy  (busy),
    .cpol  (ctrlWord[CtlCpolBit]),
    .cpha  (ctrlWord[CtlCphaBit]),
    .txData(txData),
    .miso  (miso),
    .rxData(rxData),
    .sclk  (sclk),
    .mosi  (mosi)
  );

  spim_csel #(
    .SS_LINES(SS_LINES)
  ) u_csel (
    .clk    (clk),
    .rstN   (rstN),
    .manual (ctrlWord[CtlManualBit]),
    .ssField(ctrlWord[CtlSsLsb +: SS_LINES]),
    .load   (strobe.load),
    .busy   (busy),
    .ssN    (ssN)
  );

  assign rxPush = strobe.push;

endmodule

// File: tb/spim_engine_bench.sv
module spim_engine_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ctrlWord = 16'h0000;
  logic        enable = 1'b0;
  logic        txValid = 1'b0;
  logic [31:0] txData = '0;
  logic        txPop;
  logic        rxFull = 1'b0;
  logic        rxPush;
  logic [31:0] rxData;
  logic        sclk;
  logic        mosi;
  logic        miso = 1'b0;
  logic [3:0]  ssN;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spim_engine u_spim_engine (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .enable(enable),
    .txValid(txValid), .txData(txData), .txPop(txPop),
    .rxFull(rxFull), .rxPush(rxPush), .rxData(rxData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  function automatic int pos(int i);
    return (i / 8) * 8 + 7 - (i % 8);
  endfunction

  function automatic logic [15:0] mkCtrl(bit manual, logic [3:0] field, int n, bit cpha, bit cpol);
    return {1'b0, manual, field, 4'b0000, 3'(n), cpha, cpol, 1'b1};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Plays one word through the engine while acting as the slave.
  task automatic runWord(logic [15:0] ctl, logic [31:0] txV, logic [31:0] rxV);
    bit cpolV, cphaV, manualV, popPend, pushed;
    int half, sIdx, dIdx, edges, sinceEdge, badGap, csBad, cyc;
    logic [31:0] got, rxGot;
    logic lastSclk;
    ctrlWord = ctl;
    cpolV = ctl[1]; cphaV = ctl[2]; manualV = ctl[14];
    half = 1 << ctl[5:3];
    @(negedge clk);
    check("R1 idle sclk level", 32'(sclk), 32'(cpolV));
    lastSclk = sclk;
    got = '0; rxGot = '0; sIdx = 0; edges = 0; sinceEdge = 0; badGap = 0; csBad = 0;
    cyc = 0; popPend = 0; pushed = 0;
    if (cphaV) begin dIdx = 0; miso = 1'b0; end
    else begin dIdx = 1; miso = rxV[pos(0)]; end
    txValid = 1'b1; txData = txV;
    while (!pushed && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (popPend) begin txValid = 1'b0; popPend = 0; end
      if (txPop) popPend = 1;
      sinceEdge++;
      if (sclk !== lastSclk) begin
        bit isLead, isSample;
        edges++;
        if (edges > 1 && sinceEdge != half) badGap++;
        sinceEdge = 0;
        isLead = (sclk != cpolV);
        isSample = cphaV ? !isLead : isLead;
        if (isSample) begin
          if (sIdx < 32) got[pos(sIdx)] = mosi;
          sIdx++;
        end else if (dIdx < 32) begin
          miso = rxV[pos(dIdx)];
          dIdx++;
        end
      end
      lastSclk = sclk;
      if (edges > 0 && ssN !== ctl[13:10]) csBad++;
      if (rxPush) begin pushed = 1; rxGot = rxData; end
    end
    txValid = 1'b0;
    check("R2 word accepted and completed", 32'(pushed), 32'd1);
    check("R3 R4 bits seen on mosi", got, txV);
    check("R6 received word", rxGot, rxV);
    check("R5 edge count per word", 32'(edges), 32'd64);
    check("R5 edge spacing errors", 32'(badGap), 32'd0);
    check(manualV ? "R9 select during word" : "R8 select during word", 32'(csBad), 32'd0);
    @(negedge clk);
    check("R6 single push pulse", 32'(rxPush), 32'd0);
    check(manualV ? "R9 select after word" : "R8 select after word",
          32'(ssN), manualV ? 32'(ctl[13:10]) : 32'hF);
    check("R1 sclk back at rest", 32'(sclk), 32'(cpolV));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    logic [31:0] tv;
    ctrlWord = mkCtrl(0, 4'b1110, 0, 0, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset sclk", 32'(sclk), 32'd1);
    check("R1 reset ssN", 32'(ssN), 32'hF);
    check("R1 reset txPop", 32'(txPop), 32'd0);
    check("R1 reset rxPush", 32'(rxPush), 32'd0);

    // R2: master bit clear blocks start
    ctrlWord = mkCtrl(0, 4'b1110, 0, 0, 0) & 16'hFFFE;
    txValid = 1'b1; txData = 32'h1234_5678;
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (txPop || ssN != 4'hF) seen++; end
    check("R2 no start without master bit", 32'(seen), 32'd0);

    // R7: full receive queue blocks start
    ctrlWord = mkCtrl(0, 4'b1101, 0, 0, 0);
    rxFull = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (txPop || sclk != 1'b0) seen++; end
    check("R7 no pop while receive full", 32'(seen), 32'd0);
    rxFull = 1'b0; txValid = 1'b0;
    runWord(mkCtrl(0, 4'b1101, 0, 0, 0), 32'h1234_5678, 32'h9ABC_DEF0);

    // R3 R4 R5 R6 R8: full sweep of modes and divisor codes
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 8; n++) begin
        logic [3:0] fld;
        fld = ~(4'b0001 << ((m + n) % 4));
        tv = 32'h1357_9BDF ^ (32'h0101_0101 * (m * 8 + n + 1));
        runWord(mkCtrl(0, fld, n, m[1], m[0]), tv, {tv[15:0], ~tv[31:16]});
      end
    end

    // R3: edge patterns at the fastest divisor
    runWord(mkCtrl(0, 4'b0111, 0, 0, 0), 32'h0000_0000, 32'hFFFF_FFFF);
    runWord(mkCtrl(0, 4'b0111, 0, 1, 1), 32'hFFFF_FFFF, 32'h0000_0000);
    for (int b = 0; b < 32; b += 5) begin
      runWord(mkCtrl(0, 4'b1011, 0, b[0], b[1]), 32'h1 << b, 32'h8000_0000 >> b);
    end

    // R9: manual select follows the field at all times
    ctrlWord = mkCtrl(1, 4'b1011, 0, 0, 0);
    @(negedge clk);
    check("R9 manual select idle", 32'(ssN), 32'hB);
    ctrlWord = mkCtrl(1, 4'b0110, 0, 0, 0);
    @(negedge clk);
    check("R9 manual select live change", 32'(ssN), 32'h6);
    runWord(mkCtrl(1, 4'b1110, 1, 1, 0), 32'hCAFE_F00D, 32'h0BAD_BEEF);

    // R10: drop enable in the middle of a word
    ctrlWord = mkCtrl(0, 4'b1101, 2, 0, 1);
    txValid = 1'b1; txData = 32'hDEAD_BEEF;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txPop) seen++;
      if (seen != 0 && txValid && !txPop) txValid = 1'b0;
    end
    txValid = 1'b0;
    check("R10 word had started", 32'(ssN), 32'hD);
    enable = 1'b0;
    @(negedge clk);
    check("R10 sclk returns to rest", 32'(sclk), 32'd1);
    check("R10 select released", 32'(ssN), 32'hF);
    seen = 0;
    txValid = 1'b1;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (rxPush || txPop) seen++; end
    check("R10 no push or start while disabled", 32'(seen), 32'd0);
    txValid = 1'b0;
    enable = 1'b1;
    runWord(mkCtrl(0, 4'b1101, 0, 1, 0), 32'h0F1E_2D3C, 32'h4B5A_6978);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule